// File: doc/BRIEF.md
# Receive Queue with Drain Request Flag

This block is a small first-in first-out queue that sits between a serial frame receiver and the read side of a peripheral, where either a host processor or a DMA engine collects received words. Each time the receiver finishes a frame it presents one word with a push strobe. A read of the pop port removes the oldest word. The word that the next pop will return is always visible on `pop_data`.

A drain request flag tells the host or DMA engine that words are waiting. The flag is set whenever the queue holds data. It does not drop by itself when the queue empties. It is released only in two cases: the queue is empty and the DMA side reports that its pop read has completed, or the host writes a one to the flag. A non-empty queue overrides both release paths. A sticky overflow flag records any received word that was dropped because the queue was full.

Top module: `rxq_drain_fifo`

## Requirements
- R1: A pop while the queue holds at least one word returns the oldest word on `pop_data` in the cycle of the pop and lowers `level` by exactly one at the next clock edge.
- R2: A pop while the queue is empty is ignored: `level` stays at zero and no other state changes.
- R3: While the queue is empty, `pop_data` is driven as all zeros.
- R4: `drain_req` is 1 in every cycle in which `level` is non-zero.
- R5: After the queue becomes empty, `drain_req` stays 1 until a cycle in which the queue is empty after that cycle's operations and `dma_pop_done` is 1. `drain_req` is 0 from the following edge. `dma_pop_done` has no effect while words remain.
- R6: A cycle with `flag_clr_w1` = 1 in which the queue is empty after that cycle's operations clears `drain_req` at the next edge. If words remain, the write is overridden and `drain_req` stays 1.
- R7: The queue holds DEPTH words of DATA_W bits (defaults 4 and 16). A push while full, with no pop in the same cycle, is dropped. `level` stays at DEPTH, and `overflow` becomes 1 at the next edge and stays 1 until reset.
- R8: A push and a pop in the same cycle on a non-empty queue leave `level` unchanged and keep the order of the words. This includes a full queue, where the push is accepted. A push together with a pop on an empty queue stores the word, and the pop is ignored.
- R9: After synchronous reset, `level` is 0 and `drain_req` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | Receiver has a completed word |
| push_data | input | DATA_W | Received word |
| pop_req | input | 1 | Read of the pop port this cycle |
| pop_data | output | DATA_W | Oldest word, zero when empty |
| dma_pop_done | input | 1 | DMA engine reports a completed pop read |
| flag_clr_w1 | input | 1 | Host write of one to the drain flag |
| level | output | $clog2(DEPTH+1) | Number of stored words |
| drain_req | output | 1 | Drain request flag |
| overflow | output | 1 | Sticky flag for dropped words |

## Verification
The hardest state to reach is the window in which the queue has just been emptied by host pops while the flag is still held. In this window only an empty-state DMA completion or a host clear may release the flag. The stimulus drains the queue with plain pops and holds there for several cycles. It then sends clear strobes and DMA completions both while words remain and after the queue is empty. It also lines up a last pop, a DMA completion and a push in one cycle, so that the flag is released or overridden by the operations of that same cycle. A reference queue model in the bench checks every cycle, including a long mixed random run that repeatedly fills and overflows the queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Per-cycle decision of the queue controller
    typedef struct packed {
        logic push_ok;
        logic pop_ok;
        logic drop;
    } rxq_op_t;

    // Action taken on the drain request flag
    typedef enum logic [1:0] {
        FLG_HOLD  = 2'd0,
        FLG_SET   = 2'd1,
        FLG_CLEAR = 2'd2
    } flag_act_t;

    // Circular pointer increment
    function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_ptr == PTR_W'(gi))) begin
                slot[gi] <= wr_data;
            end
        end
    end

    assign rd_data = slot[rd_ptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_d,
    output logic             drop_evt
);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    rxq_op_t op;
    logic    full;

    always_comb begin
        full       = (count_q == FULL_LVL);
        op.pop_ok  = pop_req && (count_q != '0);
        op.push_ok = push_req && (!full || op.pop_ok);
        op.drop    = push_req && full && !op.pop_ok;
        case ({op.push_ok, op.pop_ok})
            2'b10:   count_d = count_q + 1'b1;
            2'b01:   count_d = count_q - 1'b1;
            default: count_d = count_q;
        endcase
    end

    assign wr_en    = op.push_ok;
    assign drop_evt = op.drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            count_q <= count_d;
            if (op.push_ok) wr_ptr <= PTR_W'(wrap_inc(int'(wr_ptr), DEPTH));
            if (op.pop_ok)  rd_ptr <= PTR_W'(wrap_inc(int'(rd_ptr), DEPTH));
        end
    end

    // R1: a pop on a non-empty queue without a push lowers the level by one
    a_r1_pop_decrements: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

    // R2: a pop on an empty queue without a push leaves it empty
    a_r2_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && count_q == '0) |=> (count_q == '0));

    // R7: level never exceeds the depth, and a push while full alone keeps it full
    a_r7_level_bounded: assert property (@(posedge clk) disable iff (rst)
        count_q <= FULL_LVL);
    a_r7_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && full) |=> (count_q == FULL_LVL));

    // R8: simultaneous push and pop on a non-empty queue keep the level
    a_r8_push_pop_level: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && count_q != '0) |=> $stable(count_q));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nonempty_next,
    input  logic dma_done,
    input  logic clr_w1,
    input  logic drop_evt,
    output logic drain_req,
    output logic overflow
);
    flag_act_t act;

    always_comb begin
        if (nonempty_next)          act = FLG_SET;
        else if (dma_done || clr_w1) act = FLG_CLEAR;
        else                         act = FLG_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drain_req <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            case (act)
                FLG_SET:   drain_req <= 1'b1;
                FLG_CLEAR: drain_req <= 1'b0;
                default:   drain_req <= drain_req;
            endcase
            if (drop_evt) overflow <= 1'b1;
        end
    end

    // R6: a clear request while words remain is overridden
    a_r6_clear_overridden: assert property (@(posedge clk) disable iff (rst)
        (clr_w1 && nonempty_next) |=> drain_req);

    // R7: overflow is sticky until reset
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

// File: rtl/rxq_drain_fifo.sv
module rxq_drain_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    input  logic              dma_pop_done,
    input  logic              flag_clr_w1,
    output logic [CNT_W-1:0]  level,
    output logic              drain_req,
    output logic              overflow
);
    logic              wr_en;
    logic              drop_evt;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count_d;
    logic [DATA_W-1:0] head;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_valid),
        .pop_req  (pop_req),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count_q  (level),
        .count_d  (count_d),
        .drop_evt (drop_evt)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (push_data),
        .rd_ptr  (rd_ptr),
        .rd_data (head)
    );

    rxq_flags u_flags (
        .clk           (clk),
        .rst           (rst),
        .nonempty_next (count_d != '0),
        .dma_done      (dma_pop_done),
        .clr_w1        (flag_clr_w1),
        .drop_evt      (drop_evt),
        .drain_req     (drain_req),
        .overflow      (overflow)
    );

    assign pop_data = (level != '0) ? head : '0;

    // R3: empty queue presents zero data
    a_r3_empty_data_zero: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> (pop_data == '0));

    // R4: the flag is up whenever words are stored
    a_r4_flag_when_nonempty: assert property (@(posedge clk) disable iff (rst)
        (level != '0) |-> drain_req);

    // R5: an empty queue with a raised flag keeps it without a release event
    a_r5_flag_holds_empty: assert property (@(posedge clk) disable iff (rst)
        (drain_req && level == '0 && !push_valid && !dma_pop_done && !flag_clr_w1)
        |=> drain_req);
endmodule

// File: tb/rxq_drain_fifo_tb.sv
module rxq_drain_fifo_tb;
    localparam int CLK_P = 10;
    localparam int DW    = 16;
    localparam int DEP   = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          push_valid, pop_req, dma_pop_done, flag_clr_w1;
    logic [DW-1:0] push_data;
    logic [DW-1:0] pop_data;
    logic [2:0]    level;
    logic          drain_req, overflow;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int m_q[$];
    bit m_flag = 0;
    bit m_ovf  = 0;

    always #(CLK_P/2) clk = ~clk;

    rxq_drain_fifo #(.DATA_W(DW), .DEPTH(DEP)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .push_valid   (push_valid),
        .push_data    (push_data),
        .pop_req      (pop_req),
        .pop_data     (pop_data),
        .dma_pop_done (dma_pop_done),
        .flag_clr_w1  (flag_clr_w1),
        .level        (level),
        .drain_req    (drain_req),
        .overflow     (overflow)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock cycle: drive after the falling edge, check data before the
    // rising edge, update the model, check registered outputs after the edge.
    task automatic step(string tag, bit push, int data, bit pop, bit dma, bit clr);
        bit pop_ok, push_ok, full;
        @(negedge clk);
        push_valid   = push;
        push_data    = DW'(data);
        pop_req      = pop;
        dma_pop_done = dma;
        flag_clr_w1  = clr;
        #1;
        check(tag, "pop_data", int'(pop_data), (m_q.size() != 0) ? m_q[0] : 0);
        full    = (m_q.size() == DEP);
        pop_ok  = pop && (m_q.size() != 0);
        push_ok = push && (!full || pop_ok);
        if (push && full && !pop_ok) m_ovf = 1;
        if (pop_ok)  void'(m_q.pop_front());
        if (push_ok) m_q.push_back(data & 16'hFFFF);
        if (m_q.size() != 0)  m_flag = 1;
        else if (dma || clr)  m_flag = 0;
        @(posedge clk);
        #1;
        check(tag, "level", int'(level), m_q.size());
        check(tag, "drain_req", int'(drain_req), int'(m_flag));
        check(tag, "overflow", int'(overflow), int'(m_ovf));
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        push_valid = 0; pop_req = 0; dma_pop_done = 0; flag_clr_w1 = 0; push_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check("R9", "level", int'(level), 0);
        check("R9", "drain_req", int'(drain_req), 0);
        check("R9", "overflow", int'(overflow), 0);

        // R2 / R3: pops on an empty queue
        for (int i = 0; i < 3; i++) step("R2", 0, 0, 1, 0, 0);
        step("R3", 0, 0, 1, 1, 1);

        // R4 / R1: fill three, drain by host pops
        step("R4", 1, 16'h1111, 0, 0, 0);
        step("R4", 1, 16'h2222, 0, 0, 0);
        step("R4", 1, 16'h3333, 0, 0, 0);
        step("R5", 0, 0, 0, 1, 0);               // DMA done while non-empty: no effect
        for (int i = 0; i < 3; i++) step("R1", 0, 0, 1, 0, 0);
        // R5: flag held while empty until DMA completion
        for (int i = 0; i < 3; i++) step("R5", 0, 0, 0, 0, 0);
        step("R5", 0, 0, 1, 1, 0);               // empty pop + DMA done clears
        step("R5", 0, 0, 0, 0, 0);

        // R5: last pop and DMA done in the same cycle
        step("R5", 1, 16'hA5A5, 0, 0, 0);
        step("R5", 0, 0, 1, 1, 0);
        // R5: DMA done with a push in the same cycle keeps the flag
        step("R5", 1, 16'h0F0F, 0, 1, 0);
        step("R6", 0, 0, 0, 0, 1);               // clear overridden
        step("R6", 0, 0, 1, 0, 1);               // last pop + clear clears
        step("R6", 1, 16'h7777, 0, 0, 0);
        step("R1", 0, 0, 1, 0, 0);
        step("R6", 0, 0, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 1);               // clear when empty
        step("R6", 1, 16'h1234, 0, 0, 1);        // clear with push overridden
        step("R1", 0, 0, 1, 0, 0);

        // R8: push and pop on an empty queue
        step("R8", 1, 16'hBEEF, 1, 0, 0);
        step("R1", 0, 0, 1, 0, 0);

        // R7: overflow
        for (int i = 0; i < 6; i++) step("R7", 1, 16'hC000 + i, 0, 0, 0);
        // R8: push and pop while full
        step("R8", 1, 16'hD001, 1, 0, 0);
        step("R8", 1, 16'hD002, 1, 0, 0);
        for (int i = 0; i < 4; i++) step("R1", 0, 0, 1, 0, 0);
        step("R7", 0, 0, 1, 1, 0);

        // Mixed random traffic
        for (int i = 0; i < 300; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step("R8", r < 55, $urandom_range(0, 65535), (r % 3) == 0,
                 (r % 7) == 0, (r % 11) == 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule